// File: doc/BRIEF.md
# Memory Data Width Adapter

The adapter sits between a 32-bit application data port and an external memory data path whose width (8, 16 or 32 bits) is picked at run time by a 2-bit code. On the write side it splits the application word it is currently given into memory-width slices. It also splits the active-low byte enables with the data. It asks the application for the next word only when the final slice of the current word is consumed. On the read side it packs memory-width beats into 32-bit words and strobes each finished word toward the application.

A transfer engine drives the beat strobes and the burst start and last markers. The adapter turns these markers into a last-write indication on the application write side and a last-read indication on the application read side. The write side is combinational from the engine's beat strobe to the application. The read side has one register stage.

Top module: `mem_width_adapter`

## Requirements
- R1: `width_sel` picks the memory width: 2'b00 is 32 bits (one beat per word), 2'b01 is 16 bits (two beats per word), and 2'b10 or 2'b11 is 8 bits (four beats per word).
- R2: On writes, slice k of the current application word (k counted from 0 at the least significant end) appears on the low bits of `mem_wr_data` while slice k is being issued. Bits above the memory width are zero.
- R3: `mem_wr_be_n` carries the active-low enables of the bytes in the current slice, in the same low lanes as the data. Lanes above the memory width are driven 1.
- R4: `app_wr_next` is high in the same cycle as a `wr_beat` that consumes the final slice of a word or that carries `wr_last`, and is low in every other cycle. The slice position then returns to 0.
- R5: `app_wr_last` is high exactly in the cycles where `wr_beat` and `wr_last` are both high.
- R6: `wr_start` forces slice 0 in its own cycle and discards any slice position left from earlier beats.
- R7: Read beats fill the word from the low byte upward. In the cycle after the beat that completes a word, `app_rd_valid` is high for one cycle and `app_rd_data` holds the word.
- R8: A read beat with `rd_last` flushes the word in progress even if it is partial. Unfilled bytes read as zero, and `app_rd_last` is high together with `app_rd_valid` in the following cycle.
- R9: `rd_start` discards a partly assembled word. A read beat in the same cycle lands in byte position 0 of a fresh word.
- R10: While reset is held, `app_rd_valid` and `app_rd_last` are low. After reset both slice positions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_sel | input | 2 | Memory width code |
| wr_start | input | 1 | Write burst start marker from the transfer engine |
| wr_beat | input | 1 | Engine consumes one write beat this cycle |
| wr_last | input | 1 | Marks the final write beat of a burst |
| app_wr_data | input | 32 | Current application write word |
| app_wr_be_n | input | 4 | Active-low byte enables of the application word |
| app_wr_next | output | 1 | Request for the next application write word |
| app_wr_last | output | 1 | Last write of the burst, toward the application |
| mem_wr_data | output | 32 | Write slice toward memory, in the low lanes |
| mem_wr_be_n | output | 4 | Active-low byte enables of the slice |
| rd_start | input | 1 | Read burst start marker |
| rd_beat | input | 1 | A memory read beat is present |
| rd_last | input | 1 | Marks the final read beat of a burst |
| mem_rd_data | input | 32 | Read beat from memory, in the low lanes |
| app_rd_data | output | 32 | Repacked read word |
| app_rd_valid | output | 1 | One-cycle strobe for a finished read word |
| app_rd_last | output | 1 | Last read word of the burst |

## Verification
Every write-side result (slice data, byte enables, next-word request and last-write flag) is due in the same cycle as the beat that causes it. The bench therefore drives each cycle's inputs just after the falling edge and compares these outputs a moment later, before the next rising edge. Read results are due one rising edge after the completing beat. So the behavioural model computes the registered word, strobe and last flag while handling the beat, and the bench compares them in the next cycle's check window. All widths are covered by random beats, gaps, starts and lasts, including flushes of partial words and restarts in the middle of a word.

// File: rtl/mem_width_adapter.sv
module mem_width_adapter #(
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                width_sel,
  input  logic                      wr_start,
  input  logic                      wr_beat,
  input  logic                      wr_last,
  input  logic [4*BYTE_W-1:0]       app_wr_data,
  input  logic [3:0]                app_wr_be_n,
  output logic                      app_wr_next,
  output logic                      app_wr_last,
  output logic [4*BYTE_W-1:0]       mem_wr_data,
  output logic [3:0]                mem_wr_be_n,
  input  logic                      rd_start,
  input  logic                      rd_beat,
  input  logic                      rd_last,
  input  logic [4*BYTE_W-1:0]       mem_rd_data,
  output logic [4*BYTE_W-1:0]       app_rd_data,
  output logic                      app_rd_valid,
  output logic                      app_rd_last
);
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;

  logic wide, half;
  logic [1:0] last_idx;
  assign wide = (width_sel == 2'b00);
  assign half = (width_sel == 2'b01);
  assign last_idx = wide ? 2'd0 : (half ? 2'd1 : 2'd3);

  logic [1:0] wr_idx, wr_cur;
  logic       wr_end;
  assign wr_cur = wr_start ? 2'd0 : wr_idx;
  assign wr_end = (wr_cur == last_idx) || wr_last;
  assign app_wr_next = wr_beat && wr_end;
  assign app_wr_last = wr_beat && wr_last;

  always_comb begin
    mem_wr_data = '0;
    mem_wr_be_n = '1;
    if (wide) begin
      mem_wr_data = app_wr_data;
      mem_wr_be_n = app_wr_be_n;
    end else if (half) begin
      for (int k = 0; k < 2; k++)
        if (int'(wr_cur[0]) == k) begin
          mem_wr_data[HALF_W-1:0] = app_wr_data[k*HALF_W +: HALF_W];
          mem_wr_be_n[1:0]        = app_wr_be_n[k*2 +: 2];
        end
    end else begin
      for (int k = 0; k < LANES; k++)
        if (int'(wr_cur) == k) begin
          mem_wr_data[BYTE_W-1:0] = app_wr_data[k*BYTE_W +: BYTE_W];
          mem_wr_be_n[0]          = app_wr_be_n[k];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        wr_idx <= 2'd0;
    else if (wr_beat)  wr_idx <= wr_end ? 2'd0 : wr_cur + 2'd1;
    else if (wr_start) wr_idx <= 2'd0;

  logic [1:0]        rd_idx, rd_cur;
  logic [WORD_W-1:0] acc, merged;
  logic              rd_end;
  assign rd_cur = rd_start ? 2'd0 : rd_idx;
  assign rd_end = (rd_cur == last_idx) || rd_last;

  always_comb begin
    merged = rd_start ? '0 : acc;
    if (wide) begin
      merged = mem_rd_data;
    end else if (half) begin
      for (int k = 0; k < 2; k++)
        if (int'(rd_cur[0]) == k) merged[k*HALF_W +: HALF_W] = mem_rd_data[HALF_W-1:0];
    end else begin
      for (int k = 0; k < LANES; k++)
        if (int'(rd_cur) == k) merged[k*BYTE_W +: BYTE_W] = mem_rd_data[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_idx       <= 2'd0;
      acc          <= '0;
      app_rd_data  <= '0;
      app_rd_valid <= 1'b0;
      app_rd_last  <= 1'b0;
    end else if (rd_beat) begin
      if (rd_end) begin
        app_rd_data  <= merged;
        app_rd_valid <= 1'b1;
        app_rd_last  <= rd_last;
        acc          <= '0;
        rd_idx       <= 2'd0;
      end else begin
        acc          <= merged;
        rd_idx       <= rd_cur + 2'd1;
        app_rd_valid <= 1'b0;
        app_rd_last  <= 1'b0;
      end
    end else begin
      app_rd_valid <= 1'b0;
      app_rd_last  <= 1'b0;
      if (rd_start) begin
        acc    <= '0;
        rd_idx <= 2'd0;
      end
    end
endmodule

// File: rtl/mem_width_adapter_chk.sv
module mem_width_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] width_sel,
  input logic       wr_beat,
  input logic       wr_last,
  input logic       app_wr_next,
  input logic       app_wr_last,
  input logic [3:0] mem_wr_be_n,
  input logic       rd_beat,
  input logic       app_rd_valid,
  input logic       app_rd_last
);
  // R4
  wr_next_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_wr_next |-> wr_beat);
  // R5
  wr_last_with_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_wr_last |-> (app_wr_next && wr_last));
  // R1
  wide_every_beat_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel == 2'b00 && wr_beat) |-> app_wr_next);
  // R3
  half_upper_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel == 2'b01) |-> (mem_wr_be_n[3:2] == 2'b11));
  // R3
  byte_upper_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width_sel[1] |-> (mem_wr_be_n[3:1] == 3'b111));
  // R7
  rd_valid_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_rd_valid |-> $past(rd_beat));
  // R7
  wide_beat_gives_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel == 2'b00 && rd_beat) |=> app_rd_valid);
  // R8
  rd_last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_rd_last |-> app_rd_valid);
endmodule

bind mem_width_adapter mem_width_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
  .wr_beat(wr_beat), .wr_last(wr_last),
  .app_wr_next(app_wr_next), .app_wr_last(app_wr_last),
  .mem_wr_be_n(mem_wr_be_n), .rd_beat(rd_beat),
  .app_rd_valid(app_rd_valid), .app_rd_last(app_rd_last)
);

// File: tb/tb_mem_width_adapter.sv
module tb_mem_width_adapter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic wr_start = 0, wr_beat = 0, wr_last = 0;
  logic [31:0] app_wr_data = '0;
  logic [3:0]  app_wr_be_n = '1;
  logic app_wr_next, app_wr_last;
  logic [31:0] mem_wr_data;
  logic [3:0]  mem_wr_be_n;
  logic rd_start = 0, rd_beat = 0, rd_last = 0;
  logic [31:0] mem_rd_data = '0;
  logic [31:0] app_rd_data;
  logic app_rd_valid, app_rd_last;

  always #10 clk = ~clk;

  mem_width_adapter dut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .wr_start(wr_start), .wr_beat(wr_beat), .wr_last(wr_last),
    .app_wr_data(app_wr_data), .app_wr_be_n(app_wr_be_n),
    .app_wr_next(app_wr_next), .app_wr_last(app_wr_last),
    .mem_wr_data(mem_wr_data), .mem_wr_be_n(mem_wr_be_n),
    .rd_start(rd_start), .rd_beat(rd_beat), .rd_last(rd_last),
    .mem_rd_data(mem_rd_data), .app_rd_data(app_rd_data),
    .app_rd_valid(app_rd_valid), .app_rd_last(app_rd_last)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  int wi = 0, ri = 0;
  longint unsigned acc = 0;
  logic [31:0] e_rdata = '0;
  logic e_valid = 0, e_rlast = 0;
  string rtag = "R10";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input logic [1:0] ws);
    return (ws == 2'b00) ? 1 : ((ws == 2'b01) ? 2 : 4);
  endfunction

  task automatic step(input bit ws_start, input bit wb, input bit wl,
                      input bit rs, input bit rb, input bit rl);
    int nb, bw, idx, lanes;
    longint unsigned mask, lmask, e_d, e_be, merged;
    bit e_next;
    string wtag;
    @(negedge clk);
    wr_start = ws_start; wr_beat = wb; wr_last = wl;
    rd_start = rs; rd_beat = rb; rd_last = rl;
    app_wr_data = $urandom; app_wr_be_n = 4'($urandom);
    mem_rd_data = $urandom;
    #2;
    nb = beats_of(width_sel);
    bw = 32 / nb;
    lanes = bw / 8;
    mask = (64'd1 << bw) - 1;
    lmask = (64'd1 << lanes) - 1;
    idx = ws_start ? 0 : wi;
    wtag = ws_start ? "R6" : "R2";
    e_d  = (longint'(app_wr_data) >> (idx * bw)) & mask;
    e_be = ((longint'(app_wr_be_n) >> (idx * lanes)) & lmask) | (64'hF & ~lmask);
    e_next = wb && (idx == nb - 1 || wl);
    check(mem_wr_data == 32'(e_d), wtag, "write slice", mem_wr_data, e_d);
    check(mem_wr_be_n == 4'(e_be), ws_start ? "R6" : "R3", "byte enables", mem_wr_be_n, e_be);
    check(app_wr_next == e_next, "R1 R4", "next request", app_wr_next, e_next);
    check(app_wr_last == (wb && wl), "R5", "last write", app_wr_last, wb && wl);
    check(app_rd_valid == e_valid, rtag, "read valid", app_rd_valid, e_valid);
    check(app_rd_last == e_rlast, rtag, "read last", app_rd_last, e_rlast);
    if (e_valid)
      check(app_rd_data == e_rdata, rtag, "read word", app_rd_data, e_rdata);
    if (wb) wi = e_next ? 0 : idx + 1;
    else if (ws_start) wi = 0;
    idx = rs ? 0 : ri;
    if (rb) begin
      merged = (rs ? 64'd0 : acc) | ((longint'(mem_rd_data) & mask) << (idx * bw));
      rtag = rs ? "R9" : (rl ? "R8" : "R7");
      if (idx == nb - 1 || rl) begin
        e_rdata = 32'(merged); e_valid = 1; e_rlast = rl; acc = 0; ri = 0;
      end else begin
        acc = merged; ri = idx + 1; e_valid = 0; e_rlast = 0;
      end
    end else begin
      e_valid = 0; e_rlast = 0;
      if (rs) begin acc = 0; ri = 0; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL all watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(app_rd_valid == 1'b0, "R10", "valid in reset", app_rd_valid, 0);
    check(app_rd_last == 1'b0, "R10", "read last in reset", app_rd_last, 0);
    check(app_wr_next == 1'b0, "R10", "next in reset", app_wr_next, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      width_sel = 2'(w);
      wi = 0; ri = 0; acc = 0;
      step(1, 0, 0, 1, 0, 0);
      for (int n = 0; n < 24; n++) step(0, 1, 0, 0, 1, 0);
      for (int n = 0; n < 600; n++) begin
        int r = $urandom % 100;
        step(r < 6, ($urandom % 3) != 0, (r >= 6 && r < 12),
             (r >= 12 && r < 18), ($urandom % 3) != 0, (r >= 18 && r < 24));
      end
      step(0, 1, 1, 0, 1, 1);
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    finish_run();
  end
endmodule